// File: doc/BRIEF.md
# Trace RAM Sink Buffer Controller

This block is the final stage of an on-chip trace path. It takes a stream of 32-bit trace words through a valid/ready handshake and stores them in a circular region of memory. It issues one word write per accepted word through a request/grant memory port. Software programs the region with a start address and a limit address. The limit is the address of the last word that gets written, not the end of the buffer. A write pointer register tells software where the next word will land, and bit 0 of that pointer records that the buffer has wrapped at least once.

A small internal queue decouples the trace input from memory stalls. Two behaviours follow from it. Turning the sink off completes only after every queued word has reached memory, and the enable bit reads back the actual running state rather than the requested one. An optional stop-on-wrap mode freezes the buffer after the word at the limit has been written, so the oldest trace is kept instead of being overwritten. A mode bit chooses local SRAM or system memory as the destination and is presented on the memory port.

Start and limit accept any value but read back only legal ones. Each is word-aligned and clamped into a fixed address window set by parameters. While the sink runs, its region and modes are frozen.

Top module: `trace_ram_sink`

## Requirements
- R1: After reset the control word reads 0x0000_0008 (only the empty flag set). Start and write pointer read WIN_LO, limit reads WIN_HI, and tr_ready is low.
- R2: Start (low half at offset 0x10, high half at 0x14) and limit (0x18/0x1C) read back as the written 64-bit value with bits 1:0 cleared, clamped into [WIN_LO, WIN_HI]. Writing zero to the start gives WIN_LO, and writing all ones to the limit gives WIN_HI.
- R3: Each accepted trace word causes exactly one memory request carrying that word, at the current pointer. The pointer then advances by 4. A request holds its address and data steady until mem_gnt is seen.
- R4: A word written at an address at or above the limit returns the pointer to the start and sets the wrap flag. The wrap flag is bit 0 of the pointer low half (offset 0x20; high half at 0x24).
- R5: With stop-on-wrap (control bit 8) set, no memory write follows the one that wrapped. tr_ready stays low, and any words still queued are dropped.
- R6: The sink runs only when both the active bit (control bit 0) and the enable bit (control bit 1) are written as 1. Control bit 1 reads back the actual running state, and tr_ready is low whenever the sink is not running.
- R7: After enable is cleared, control bit 1 reads 1 and the empty flag (control bit 3) reads 0 until all queued words have been written. After that, bit 1 reads 0 and bit 3 reads 1.
- R8: While running, writes to start, limit, mode (control bit 4) and stop-on-wrap are ignored.
- R9: Writes to the write pointer take effect only while the sink is not running. A write to the low half clears the wrap flag.
- R10: Control bit 4 (0 = local SRAM, 1 = system memory) is driven on mem_sel.
- R11: With mem_gnt held low, the sink accepts FIFO_DEPTH+1 words (one in the pending request, the rest queued) and then holds tr_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata one cycle later |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| tr_valid | input | 1 | Trace word valid |
| tr_data | input | 32 | Trace word |
| tr_ready | output | 1 | Sink can accept a trace word |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 64 | Byte address of the write |
| mem_data | output | 32 | Data of the write |
| mem_sel | output | 1 | Destination: 0 local SRAM, 1 system memory |
| mem_gnt | input | 1 | Memory accepts the pending request |

## Verification
The main storage path is tried with three traffic patterns. A short run with the grant always high shows the plain pointer advance. A run that crosses a four-word region shows whether wrap returns to the start and sets the flag exactly at the limit. A run with the grant withheld separates correct queue depth and backpressure from lost or duplicated words, and it also reveals whether disable waits for the drain. Stop-on-wrap is run over the same small region, so the count of memory writes shows whether the freeze happens after the write at the limit and not one word early or late. Register writes made while running, and again while stopped, show which fields are frozen.

// File: rtl/trace_sink_pkg.sv
package trace_sink_pkg;
  localparam int ADDR_W = 64;
  localparam int WORD_W = 32;

  localparam logic [7:0] OFS_CTRL     = 8'h00;
  localparam logic [7:0] OFS_START_LO = 8'h10;
  localparam logic [7:0] OFS_START_HI = 8'h14;
  localparam logic [7:0] OFS_LIMIT_LO = 8'h18;
  localparam logic [7:0] OFS_LIMIT_HI = 8'h1C;
  localparam logic [7:0] OFS_WPTR_LO  = 8'h20;
  localparam logic [7:0] OFS_WPTR_HI  = 8'h24;

  localparam int B_ACTIVE = 0;
  localparam int B_ENABLE = 1;
  localparam int B_EMPTY  = 3;
  localparam int B_MODE   = 4;
  localparam int B_STOPWR = 8;

  function automatic logic [ADDR_W-1:0] clamp_addr(
    input logic [ADDR_W-1:0] v,
    input logic [ADDR_W-1:0] lo,
    input logic [ADDR_W-1:0] hi);
    logic [ADDR_W-1:0] a;
    a = {v[ADDR_W-1:2], 2'b00};
    if (a < lo)      clamp_addr = lo;
    else if (a > hi) clamp_addr = hi;
    else             clamp_addr = a;
  endfunction
endpackage

// File: rtl/trace_sink_fifo.sv
module trace_sink_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst) push |-> !full)
    else $error("fifo push while full");
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst) pop |-> !empty)
    else $error("fifo pop while empty");
endmodule

// File: rtl/trace_sink_regs.sv
module trace_sink_regs
  import trace_sink_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_LO = 64'h1000,
  parameter logic [ADDR_W-1:0] WIN_HI = 64'hFFFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              running,
  input  logic              empty,
  input  logic [ADDR_W-1:0] wptr,
  input  logic              wrap,
  output logic              active,
  output logic              en_req,
  output logic              mode,
  output logic              stop_wrap,
  output logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] limit_addr,
  output logic              wp_wr_lo,
  output logic              wp_wr_hi
);
  logic frozen_ok;
  assign frozen_ok = !running;

  assign wp_wr_lo = reg_wr && (reg_addr == OFS_WPTR_LO) && frozen_ok;
  assign wp_wr_hi = reg_wr && (reg_addr == OFS_WPTR_HI) && frozen_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      en_req     <= 1'b0;
      mode       <= 1'b0;
      stop_wrap  <= 1'b0;
      start_addr <= WIN_LO;
      limit_addr <= WIN_HI;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_CTRL: begin
          active <= reg_wdata[B_ACTIVE];
          en_req <= reg_wdata[B_ENABLE];
          if (frozen_ok) begin
            mode      <= reg_wdata[B_MODE];
            stop_wrap <= reg_wdata[B_STOPWR];
          end
        end
        OFS_START_LO: if (frozen_ok)
          start_addr <= clamp_addr({start_addr[63:32], reg_wdata}, WIN_LO, WIN_HI);
        OFS_START_HI: if (frozen_ok)
          start_addr <= clamp_addr({reg_wdata, start_addr[31:0]}, WIN_LO, WIN_HI);
        OFS_LIMIT_LO: if (frozen_ok)
          limit_addr <= clamp_addr({limit_addr[63:32], reg_wdata}, WIN_LO, WIN_HI);
        OFS_LIMIT_HI: if (frozen_ok)
          limit_addr <= clamp_addr({reg_wdata, limit_addr[31:0]}, WIN_LO, WIN_HI);
        default: ;
      endcase
    end
  end

  logic [31:0] ctrl_word;
  always_comb begin
    ctrl_word           = '0;
    ctrl_word[B_ACTIVE] = active;
    ctrl_word[B_ENABLE] = running;
    ctrl_word[B_EMPTY]  = empty;
    ctrl_word[B_MODE]   = mode;
    ctrl_word[B_STOPWR] = stop_wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_CTRL:     reg_rdata <= ctrl_word;
        OFS_START_LO: reg_rdata <= start_addr[31:0];
        OFS_START_HI: reg_rdata <= start_addr[63:32];
        OFS_LIMIT_LO: reg_rdata <= limit_addr[31:0];
        OFS_LIMIT_HI: reg_rdata <= limit_addr[63:32];
        OFS_WPTR_LO:  reg_rdata <= {wptr[31:1], wrap};
        OFS_WPTR_HI:  reg_rdata <= wptr[63:32];
        default:      reg_rdata <= '0;
      endcase
    end
  end

  a_r8_region_frozen: assert property (@(posedge clk) disable iff (rst)
    running |=> $stable(start_addr) && $stable(limit_addr) && $stable(mode) && $stable(stop_wrap))
    else $error("region or mode changed while running");
  a_r2_start_in_window: assert property (@(posedge clk) disable iff (rst)
    start_addr >= WIN_LO && start_addr <= WIN_HI && limit_addr >= WIN_LO && limit_addr <= WIN_HI)
    else $error("start or limit outside window");
endmodule

// File: rtl/trace_sink_writer.sv
module trace_sink_writer
  import trace_sink_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_LO = 64'h1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              stop_wrap,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] limit_addr,
  input  logic              wp_wr_lo,
  input  logic              wp_wr_hi,
  input  logic [31:0]       wp_wdata,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_head,
  output logic              fifo_pop,
  output logic              running,
  output logic              halted,
  output logic              drained,
  output logic [ADDR_W-1:0] wptr,
  output logic              wrap,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data,
  input  logic              mem_gnt
);
  logic issue, flush, at_limit;

  assign halted   = stop_wrap && wrap;
  assign drained  = fifo_empty && !mem_req;
  assign at_limit = (wptr >= limit_addr);
  assign issue    = running && !halted && !fifo_empty && (!mem_req || mem_gnt);
  assign flush    = halted && !fifo_empty;
  assign fifo_pop = issue || flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
    end else if (!running) begin
      running <= go;
    end else if (!go && drained) begin
      running <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= WIN_LO;
      wrap     <= 1'b0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      if (issue) begin
        mem_req  <= 1'b1;
        mem_addr <= wptr;
        mem_data <= fifo_head;
        if (at_limit) begin
          wptr <= start_addr;
          wrap <= 1'b1;
        end else begin
          wptr <= wptr + 64'd4;
        end
      end else begin
        if (mem_gnt) mem_req <= 1'b0;
        if (wp_wr_lo) begin
          wptr[31:0] <= {wp_wdata[31:2], 2'b00};
          wrap       <= 1'b0;
        end
        if (wp_wr_hi) wptr[63:32] <= wp_wdata;
      end
    end
  end

  a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_data))
    else $error("request dropped or changed before grant");
  a_r4_wrap_with_write: assert property (@(posedge clk) disable iff (rst)
    $rose(wrap) |-> mem_req)
    else $error("wrap flag set without a write");
  a_r5_no_write_after_halt: assert property (@(posedge clk) disable iff (rst)
    halted && !mem_req |=> !mem_req)
    else $error("write issued after stop on wrap");
  a_r7_stop_waits_drain: assert property (@(posedge clk) disable iff (rst)
    running && !go && !drained |=> running)
    else $error("sink stopped before drain");
endmodule

// File: rtl/trace_ram_sink.sv
module trace_ram_sink
  import trace_sink_pkg::*;
#(
  parameter logic [63:0] WIN_LO     = 64'h1000,
  parameter logic [63:0] WIN_HI     = 64'hFFFC,
  parameter int          FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tr_valid,
  input  logic [31:0] tr_data,
  output logic        tr_ready,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  output logic [31:0] mem_data,
  output logic        mem_sel,
  input  logic        mem_gnt
);
  logic              active, en_req, mode, stop_wrap, go;
  logic [ADDR_W-1:0] start_addr, limit_addr, wptr;
  logic              wp_wr_lo, wp_wr_hi;
  logic              running, halted, drained, wrap;
  logic              f_empty, f_full, f_pop, f_push;
  logic [WORD_W-1:0] f_head;

  assign go       = active && en_req;
  assign tr_ready = running && go && !halted && !f_full;
  assign f_push   = tr_valid && tr_ready;
  assign mem_sel  = mode;

  trace_sink_regs #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .running(running), .empty(drained),
    .wptr(wptr), .wrap(wrap), .active(active), .en_req(en_req), .mode(mode),
    .stop_wrap(stop_wrap), .start_addr(start_addr), .limit_addr(limit_addr),
    .wp_wr_lo(wp_wr_lo), .wp_wr_hi(wp_wr_hi));

  trace_sink_fifo #(.DW(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(f_push), .din(tr_data), .pop(f_pop),
    .dout(f_head), .empty(f_empty), .full(f_full));

  trace_sink_writer #(.WIN_LO(WIN_LO)) u_writer (
    .clk(clk), .rst(rst), .go(go), .stop_wrap(stop_wrap), .start_addr(start_addr),
    .limit_addr(limit_addr), .wp_wr_lo(wp_wr_lo), .wp_wr_hi(wp_wr_hi),
    .wp_wdata(reg_wdata), .fifo_empty(f_empty), .fifo_head(f_head), .fifo_pop(f_pop),
    .running(running), .halted(halted), .drained(drained), .wptr(wptr), .wrap(wrap),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_gnt(mem_gnt));

  a_r6_idle_not_ready: assert property (@(posedge clk) disable iff (rst)
    !running |-> !tr_ready)
    else $error("ready while not running");
endmodule

// File: tb/trace_ram_sink_tb.sv
module trace_ram_sink_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tr_valid = 1'b0;
  logic [31:0] tr_data = '0;
  logic        tr_ready;
  logic        mem_req, mem_sel;
  logic [63:0] mem_addr;
  logic [31:0] mem_data;
  logic        mem_gnt = 1'b1;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;
  logic [63:0] log_addr [64];
  logic [31:0] log_data [64];
  int log_n = 0;

  always #5 clk = ~clk;

  trace_ram_sink u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tr_valid(tr_valid), .tr_data(tr_data),
    .tr_ready(tr_ready), .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_sel(mem_sel), .mem_gnt(mem_gnt));

  always @(posedge clk) begin
    if (!rst && mem_req && mem_gnt && log_n < 64) begin
      log_addr[log_n] <= mem_addr;
      log_data[log_n] <= mem_data;
      log_n <= log_n + 1;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 20000", cycles);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic send_word(input logic [31:0] d, input int maxw, output bit ok);
    ok = 1'b0;
    @(negedge clk); tr_valid = 1'b1; tr_data = d;
    for (int i = 0; i < maxw; i++) begin
      if (tr_ready) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    if (ok) @(posedge clk);
    #1 tr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1: reset state
  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 ctrl", v, 32'h8);
    rd(8'h10, v); chk("R1 start lo", v, 32'h1000);
    rd(8'h18, v); chk("R1 limit lo", v, 32'hFFFC);
    rd(8'h20, v); chk("R1 wptr lo", v, 32'h1000);
    chk("R1 tr_ready", tr_ready, 0);
  endtask

  // R2: clamping and alignment
  task automatic t_clamp();
    logic [31:0] v;
    wr(8'h10, 32'h0);        rd(8'h10, v); chk("R2 start zero", v, 32'h1000);
    wr(8'h10, 32'h2003);     rd(8'h10, v); chk("R2 start aligned", v, 32'h2000);
    wr(8'h18, 32'hFFFFFFFF); wr(8'h1C, 32'hFFFFFFFF);
    rd(8'h18, v); chk("R2 limit ones lo", v, 32'hFFFC);
    rd(8'h1C, v); chk("R2 limit ones hi", v, 32'h0);
    wr(8'h18, 32'h200E);     rd(8'h18, v); chk("R2 limit aligned", v, 32'h200C);
  endtask

  // R6: active bit required, enable reads actual state
  task automatic t_enable();
    logic [31:0] v;
    wr(8'h20, 32'h2000);
    wr(8'h00, 32'h2); idle(2);
    rd(8'h00, v); chk("R6 no active", v, 32'h8);
    chk("R6 ready idle", tr_ready, 0);
    wr(8'h00, 32'h3); idle(1);
    rd(8'h00, v); chk("R6 running", v, 32'hB);
  endtask

  // R3, R8, R9: plain stream and frozen registers
  task automatic t_stream();
    logic [31:0] v; bit ok; int b;
    b = log_n;
    for (int i = 0; i < 3; i++) send_word(32'hA0 + i, 20, ok);
    idle(4);
    chk("R3 count", log_n - b, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R3 addr", log_addr[b+i], 64'h2000 + 4*i);
      chk("R3 data", log_data[b+i], 32'hA0 + i);
    end
    rd(8'h20, v); chk("R3 wptr", v, 32'h200C);
    wr(8'h10, 32'h4000); rd(8'h10, v); chk("R8 start frozen", v, 32'h2000);
    wr(8'h18, 32'h5000); rd(8'h18, v); chk("R8 limit frozen", v, 32'h200C);
    wr(8'h00, 32'h113);  idle(1); chk("R8 mode frozen", mem_sel, 0);
    rd(8'h00, v); chk("R8 stop frozen", v, 32'hB);
    wr(8'h20, 32'h5000); rd(8'h20, v); chk("R9 wptr frozen", v, 32'h200C);
  endtask

  // R4: wrap at limit
  task automatic t_wrap();
    logic [31:0] v; bit ok; int b;
    b = log_n;
    for (int i = 0; i < 3; i++) send_word(32'hB0 + i, 20, ok);
    idle(4);
    chk("R4 addr limit", log_addr[b], 64'h200C);
    chk("R4 addr start", log_addr[b+1], 64'h2000);
    chk("R4 addr next", log_addr[b+2], 64'h2004);
    rd(8'h20, v); chk("R4 wptr wrap", v, 32'h2009);
    wr(8'h00, 32'h1); idle(3);
    rd(8'h00, v); chk("R7 stopped", v, 32'h9);
    wr(8'h20, 32'h2000); rd(8'h20, v); chk("R9 wptr clear wrap", v, 32'h2000);
  endtask

  // R5: stop on wrap
  task automatic t_stopwrap();
    logic [31:0] v; bit ok; int b;
    wr(8'h00, 32'h101); wr(8'h00, 32'h103); idle(1);
    b = log_n;
    for (int i = 0; i < 6; i++) send_word(32'hC0 + i, 8, ok);
    idle(4);
    chk("R5 writes", log_n - b, 4);
    chk("R5 last addr", log_addr[b+3], 64'h200C);
    chk("R5 ready low", tr_ready, 0);
    rd(8'h20, v); chk("R5 wptr", v, 32'h2001);
    wr(8'h00, 32'h101); idle(3);
    rd(8'h00, v); chk("R5 disabled", v, 32'h109);
  endtask

  // R10: destination mode pin
  task automatic t_mode();
    logic [31:0] v;
    wr(8'h00, 32'h11); idle(1);
    chk("R10 sel sys", mem_sel, 1);
    rd(8'h00, v); chk("R10 readback", v, 32'h19);
    wr(8'h00, 32'h1); idle(1);
    chk("R10 sel sram", mem_sel, 0);
  endtask

  // R11 and R7: backpressure and drain before stop
  task automatic t_drain();
    logic [31:0] v; bit ok; int b, acc;
    wr(8'h18, 32'hFFFFFFFF); wr(8'h20, 32'h3000);
    wr(8'h00, 32'h3); idle(1);
    @(negedge clk); mem_gnt = 1'b0;
    b = log_n; acc = 0;
    for (int i = 0; i < 7; i++) begin
      send_word(32'hD0 + i, 6, ok);
      if (ok) acc++;
    end
    chk("R11 accepted", acc, 5);
    chk("R11 ready low", tr_ready, 0);
    wr(8'h00, 32'h1); idle(2);
    rd(8'h00, v); chk("R7 still running", v, 32'h3);
    chk("R7 req pending", mem_req, 1);
    @(negedge clk); mem_gnt = 1'b1;
    idle(12);
    rd(8'h00, v); chk("R7 drained", v, 32'h9);
    chk("R7 words written", log_n - b, 5);
    for (int i = 0; i < 5; i++) begin
      chk("R3 drain addr", log_addr[b+i], 64'h3000 + 4*i);
      chk("R3 drain data", log_data[b+i], 32'hD0 + i);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_clamp();
    t_enable();
    t_stream();
    t_wrap();
    t_stopwrap();
    t_mode();
    t_drain();
    done = 1'b1;
    summary();
  end
endmodule